// File: doc/BRIEF.md
# Serial Sign-First Complement Converter

This block rewrites a bit-serial signed word from sign-magnitude form into two's-complement form, one bit per clock. Because the conversion is its own inverse, the same datapath also turns two's-complement words back into sign-magnitude. Each word opens with its sign bit, marked by a start-of-word strobe. The magnitude bits follow, least significant bit first.

The block stores the sign as it arrives and uses it to steer complementation of the later bits as they stream past. A second one-bit flag records whether a 1 has already gone by in the current word. The converted stream leaves the block exactly one clock after it enters, together with a valid flag, a start marker and a marker on the final bit of the word.

The word length, counted with the sign bit, is set by a parameter. Idle cycles may appear anywhere in the stream.

Top module: `sc_serial_conv`

## Requirements
- R1: Every output follows its input beat by exactly one clock: `out_valid` equals the `in_valid` of the previous cycle. While `out_valid` is 0, `out_bit`, `out_first` and `out_last` are all 0.
- R2: A beat with `in_valid`=1 and `in_first`=1 carries the sign bit (1 = negative). It is forwarded unchanged with `out_first`=1.
- R3: After a sign of 0, every magnitude bit is forwarded unchanged.
- R4: After a sign of 1, magnitude bits pass unchanged up to and including the first 1 bit of the word, and every later bit of that word is inverted. Over a full word the magnitude field becomes (2^(WIDTH-1) − magnitude) mod 2^(WIDTH-1), sent LSB first.
- R5: A negative word whose magnitude bits are all 0 comes out unchanged (negative zero in, negative zero out).
- R6: A start-of-word beat loads the new sign and clears the seen-one flag, even when the previous word was cut short. Magnitude beats that arrive after reset and before any start-of-word beat are treated as belonging to a positive word.
- R7: `out_last` is 1 only on the beat at position WIDTH−1 after the start beat, with the sign beat counted as position 0. Cycles with `in_valid`=0 neither advance the position nor change the sign or seen-one state.
- R8: Two converters in cascade give back the original stream: bits, valid flags and start markers, two clocks later.
- R9: While `rst` is 1, all outputs are 0 at each clock and both state bits are cleared, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_first | input | 1 | Input beat is the sign bit that opens a word |
| in_bit | input | 1 | Serial input data bit |
| out_valid | output | 1 | Output beat present |
| out_first | output | 1 | Output beat is the sign bit |
| out_last | output | 1 | Output beat is the final bit of the word |
| out_bit | output | 1 | Converted serial data bit |

## Verification
The assertions assume that `in_first` is only meaningful together with `in_valid`. They also assume that the bits between two start beats belong to one word, and they do not require that a word be complete before the next one starts. The stimulus always raises `in_first` together with `in_valid`. It mixes full words, a word cut short and then restarted, idle cycles in the middle of words, and bits sent before any start beat. Every input that the bench drives is a defined 0 or 1, so the properties never see an unknown value.

// File: rtl/sc_pkg.sv
package sc_pkg;

  // One beat of the serial stream as carried to the output stage.
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
    logic data;
  } sc_beat_t;

  localparam sc_beat_t SC_IDLE = '{valid: 1'b0, first: 1'b0, last: 1'b0, data: 1'b0};

endpackage

// File: rtl/sc_word_pos.sv
// Tracks the position of the current beat inside its word and flags the final bit.
module sc_word_pos #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic first,
  output logic is_last
);

  localparam int POS_W = $clog2(WIDTH + 1);
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(WIDTH);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(WIDTH - 1);

  // Position of the next magnitude bit; POS_IDLE means no word is open.
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= POS_IDLE;
    end else if (step) begin
      if (first) begin
        pos_q <= POS_W'(1);
      end else if (pos_q != POS_IDLE) begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign is_last = step && !first && (pos_q == POS_END);

endmodule

// File: rtl/sc_flip_core.sv
// Two-flop serial converter: the captured sign and a flag for "a 1 has passed".
module sc_flip_core (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic first,
  input  logic din,
  output logic dout,
  output logic sign_q,
  output logic seen_q
);

  logic invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (valid) begin
      if (first) begin
        sign_q <= din;
        seen_q <= 1'b0;
      end else begin
        seen_q <= seen_q | din;
      end
    end
  end

  // Sign beats pass untouched; later bits flip only once a 1 has gone by in a negative word.
  assign invert = !first && sign_q && seen_q;
  assign dout   = din ^ invert;

endmodule

// File: rtl/sc_out_stage.sv
// Output register: one clock of latency, outputs forced to 0 on idle beats.
module sc_out_stage
  import sc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sc_beat_t beat_d,
  output sc_beat_t beat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= SC_IDLE;
    end else if (beat_d.valid) begin
      beat_q <= beat_d;
    end else begin
      beat_q <= SC_IDLE;
    end
  end

endmodule

// File: rtl/sc_serial_conv.sv
module sc_serial_conv
  import sc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_first,
  input  logic in_bit,
  output logic out_valid,
  output logic out_first,
  output logic out_last,
  output logic out_bit
);

  logic     conv_bit;
  logic     last_hit;
  logic     sign_lat;
  logic     seen_lat;
  sc_beat_t next_beat;
  sc_beat_t held_beat;

  sc_flip_core u_core (
    .clk   (clk),
    .rst   (rst),
    .valid (in_valid),
    .first (in_first),
    .din   (in_bit),
    .dout  (conv_bit),
    .sign_q(sign_lat),
    .seen_q(seen_lat)
  );

  sc_word_pos #(.WIDTH(WIDTH)) u_pos (
    .clk    (clk),
    .rst    (rst),
    .step   (in_valid),
    .first  (in_first),
    .is_last(last_hit)
  );

  always_comb begin
    next_beat.valid = in_valid;
    next_beat.first = in_first;
    next_beat.last  = last_hit;
    next_beat.data  = conv_bit;
  end

  sc_out_stage u_out (
    .clk   (clk),
    .rst   (rst),
    .beat_d(next_beat),
    .beat_q(held_beat)
  );

  assign out_valid = held_beat.valid;
  assign out_first = held_beat.first;
  assign out_last  = held_beat.last;
  assign out_bit   = held_beat.data;

endmodule

// File: rtl/sc_serial_conv_chk.sv
module sc_serial_conv_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_first,
  input logic in_bit,
  input logic out_valid,
  input logic out_first,
  input logic out_last,
  input logic out_bit,
  input logic sign_lat,
  input logic seen_lat
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follows_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_bit && !out_first && !out_last);

  p_sign_forward_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_first |=> out_first && (out_bit == $past(in_bit)));

  p_positive_pass_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_first && !sign_lat |=> out_bit == $past(in_bit));

  p_neg_before_one_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_first && sign_lat && !seen_lat |=> out_bit == $past(in_bit));

  p_neg_after_one_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_first && sign_lat && seen_lat |=> out_bit != $past(in_bit));

  p_seen_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    seen_lat && !(in_valid && in_first) |=> seen_lat);

  p_start_loads_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_first |=> !seen_lat && (sign_lat == $past(in_bit)));

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sign_lat) && $stable(seen_lat));

  p_last_in_word_r7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid && !out_first);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> !out_valid && !sign_lat && !seen_lat);

endmodule

bind sc_serial_conv sc_serial_conv_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_first (in_first),
  .in_bit   (in_bit),
  .out_valid(out_valid),
  .out_first(out_first),
  .out_last (out_last),
  .out_bit  (out_bit),
  .sign_lat (sign_lat),
  .seen_lat (seen_lat)
);

// File: tb/sc_serial_conv_test.sv
module sc_serial_conv_test;

  localparam int W  = 8;
  localparam int MW = W - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_first = 1'b0, in_bit = 1'b0;
  logic o_valid, o_first, o_last, o_bit;
  logic b_valid, b_first, b_last, b_bit;

  sc_serial_conv #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_bit(in_bit),
    .out_valid(o_valid), .out_first(o_first), .out_last(o_last), .out_bit(o_bit)
  );

  sc_serial_conv #(.WIDTH(W)) uut_back (
    .clk(clk), .rst(rst), .in_valid(o_valid), .in_first(o_first), .in_bit(o_bit),
    .out_valid(b_valid), .out_first(b_first), .out_last(b_last), .out_bit(b_bit)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Expected uut output after the most recent drive.
  logic e_valid = 1'b0, e_first = 1'b0, e_last = 1'b0, e_bit = 1'b0;
  string e_tag = "R9";
  // Original beats one and two drives back, for the cascade check (R8).
  logic [2:0] p1 = 3'b000, p2 = 3'b000;
  bit rt_on = 1'b0;

  task automatic compare();
    checks++;
    if ({o_valid, o_first, o_last, o_bit} !== {e_valid, e_first, e_last, e_bit}) begin
      errors++;
      $display("FAIL %s: valid/first/last/bit actual %b%b%b%b expected %b%b%b%b at %0t",
               e_tag, o_valid, o_first, o_last, o_bit, e_valid, e_first, e_last, e_bit, $time);
    end
    if (rt_on) begin
      checks++;
      if ({b_valid, b_first, b_bit} !== p2) begin
        errors++;
        $display("FAIL R8: round trip valid/first/bit actual %b%b%b expected %b at %0t",
                 b_valid, b_first, b_bit, p2, $time);
      end
    end
  endtask

  task automatic beat(input logic v, input logic f, input logic b,
                      input logic ev, input logic ef, input logic el, input logic eb,
                      input string tag);
    @(negedge clk);
    compare();
    in_valid = v; in_first = f; in_bit = b;
    e_valid = ev; e_first = ef; e_last = el; e_bit = eb; e_tag = tag;
    p2 = p1;
    p1 = {v, v & f, v & b};
  endtask

  task automatic idle(input string tag);
    beat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Sends the first nbits beats of a word; an idle cycle follows magnitude bit gap_at.
  task automatic send_word(input logic s, input int mag, input int nbits,
                           input int gap_at, input string tag);
    int conv;
    conv = (-mag) & ((1 << MW) - 1);
    beat(1'b1, 1'b1, s, 1'b1, 1'b1, 1'b0, s, "R2");
    for (int k = 1; k < nbits; k++) begin
      logic mb, cb;
      mb = mag[k-1];
      cb = s ? conv[k-1] : mb;
      beat(1'b1, 1'b0, mb, 1'b1, 1'b0, (k == W - 1), cb, tag);
      if (k == gap_at) idle("R7");
    end
  endtask

  initial begin
    // R9: reset holds the outputs low even with active inputs.
    beat(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    beat(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    idle("R9");
    rst = 1'b0;
    idle("R9");
    idle("R1");
    rt_on = 1'b1;

    // R6: bits before any start beat behave as a positive word.
    beat(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
    beat(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    beat(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
    idle("R1");

    send_word(1'b0, 'h2D, W, -1, "R3");
    send_word(1'b1, 'h2C, W, -1, "R4");
    send_word(1'b1, 'h00, W, -1, "R5");
    send_word(1'b1, 'h40, W, -1, "R4");
    send_word(1'b1, 'h7F, W, -1, "R4");
    send_word(1'b0, 'h7F, W, -1, "R3");
    send_word(1'b1, 'h16, W, 2, "R7");
    send_word(1'b1, 'h01, W, 1, "R7");
    // R6: a negative word cut short, then a fresh positive word.
    send_word(1'b1, 'h03, 3, -1, "R4");
    send_word(1'b0, 'h55, W, -1, "R6");
    idle("R1");

    for (int n = 0; n < 300; n++) begin
      logic s;
      int mag, gap;
      s   = 1'($urandom % 2);
      mag = int'($urandom_range(0, (1 << MW) - 1));
      gap = ($urandom % 3 == 0) ? int'($urandom_range(1, W - 1)) : -1;
      send_word(s, mag, W, gap, s ? "R4" : "R3");
      if ($urandom % 4 == 0) idle("R1");
    end

    idle("R1");
    idle("R1");
    idle("R8");
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule